// File: doc/BRIEF.md
# Multi-format palette pixel converter

This block turns a stream of pixel codes into digital red, green and blue values for three video DACs. Each pixel arrives with a valid strobe. It is decoded under one of four formats. The first is an indexed format, where the low byte of the pixel selects an entry of an 18-bit palette. The second is a 5-5-5 direct format, the third a 5-6-5 direct format, and the fourth a 24-bit direct format. In the 24-bit format each channel byte passes through its own 256-entry gamma table, and a separate order bit picks RGB or BGR byte order. With the format select left at indexed, the block acts as a plain indexed-palette RAMDAC.

A host write port loads the palette and the gamma tables one channel entry at a time. The pixel stream never stalls for it. Every result leaves two cycles after its pixel, whatever the format, so the outputs stay aligned with the display timing signals. A format change made while pixels are streaming is held back until the first cycle with no pixel. A single pixel is therefore never decoded under two formats.

Top module: `pal_pixel_conv`

## Requirements
- R1: While reset is asserted, and afterwards until the first result, `out_valid` is 0 and `out_r`, `out_g` and `out_b` are 0. Whenever `out_valid` is 0, all three colour outputs are 0. Reset selects the indexed format in RGB order.
- R2: A pixel accepted at a rising edge (with `pix_valid` high) produces `out_valid` high with its colour after the second rising edge that follows. This holds in every format and for back-to-back pixels, with no gaps.
- R3: In indexed format (`fmt_sel` = 2'b00), `pix_data[7:0]` addresses the palette and `pix_data[23:8]` is ignored. Each colour output is the 6-bit palette value v widened to 8 bits as {v, v[5:4]}.
- R4: In 5-5-5 format (`fmt_sel` = 2'b01), red is `pix_data[14:10]`, green is `[9:5]` and blue is `[4:0]`, each widened as {x, x[4:2]}. Bits 15 to 23 are ignored.
- R5: In 5-6-5 format (`fmt_sel` = 2'b10), red is `pix_data[15:11]` and blue is `[4:0]`, each widened as {x, x[4:2]}. Green is `[10:5]`, widened as {x, x[5:4]}.
- R6: In 24-bit format (`fmt_sel` = 2'b11) with `fmt_bgr` = 0, the red gamma table is addressed by `pix_data[23:16]`, the green table by `[15:8]` and the blue table by `[7:0]`. Each output is the 8-bit table entry.
- R7: In 24-bit format with `fmt_bgr` = 1, the blue table is addressed by `pix_data[23:16]`, the green table by `[15:8]` and the red table by `[7:0]`.
- R8: A host write (`wr_en` = 1) stores `wr_data` at `wr_addr` in one table. `wr_lut` = 0 selects the palette, which keeps `wr_data[5:0]`, and `wr_lut` = 1 selects a gamma table. `wr_chan` picks the channel: 0 for red, 1 for green, 2 for blue. Pixels presented in the following cycle or later see the new entry.
- R9: A pixel that reads an entry in the same cycle as a host write to that entry gets the old entry. The pixel stream is not delayed.
- R10: `fmt_sel` and `fmt_bgr` are taken in only at rising edges where `pix_valid` is 0. A pixel is decoded with the format in force when it was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_sel | input | 2 | Requested pixel format |
| fmt_bgr | input | 1 | Requested 24-bit byte order (1 = BGR) |
| pix_valid | input | 1 | Pixel strobe |
| pix_data | input | 24 | Pixel code |
| wr_en | input | 1 | Host write strobe |
| wr_lut | input | 1 | Host write target: 0 palette, 1 gamma table |
| wr_chan | input | 2 | Host write channel: 0 red, 1 green, 2 blue |
| wr_addr | input | 8 | Host write entry address |
| wr_data | input | 8 | Host write data |
| out_valid | output | 1 | Colour result valid |
| out_r | output | 8 | Red value |
| out_g | output | 8 | Green value |
| out_b | output | 8 | Blue value |

## Verification
The bench builds the block with its default parameters: an 8-bit palette index, 6-bit palette entries and 8-bit direct channels. With these values all 256 entries of every palette and gamma table can be loaded and read back within a short run. The widening patterns from 5 and 6 bits to a full byte can be checked exactly, and the byte swap between RGB and BGR order lands on distinct tables. Same-cycle write and read collisions are driven on the palette and on a gamma table. A format change is also requested in the middle of a pixel burst.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
   typedef enum logic [1:0] {
      FMT_INDEX  = 2'b00,
      FMT_RGB555 = 2'b01,
      FMT_RGB565 = 2'b10,
      FMT_TRUE   = 2'b11
   } fmt_e;

   localparam int NUM_CH = 3;
endpackage

// File: rtl/ppc_ram.sv
module ppc_ram #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   // read-before-write: a colliding read returns the previous entry
   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/ppc_widen.sv
module ppc_widen #(
   parameter int IN_W  = 5,
   parameter int OUT_W = 8
) (
   input  logic [IN_W-1:0]  din,
   output logic [OUT_W-1:0] dout
);
   localparam int PAD_W = OUT_W - IN_W;

   generate
      if (PAD_W == 0) begin : g_pass
         assign dout = din;
      end else if (PAD_W > 0 && PAD_W <= IN_W) begin : g_repl
         assign dout = {din, din[IN_W-1 -: PAD_W]};
      end else begin : g_bad
         $error("ppc_widen: OUT_W must lie between IN_W and 2*IN_W");
      end
   endgenerate
endmodule

// File: rtl/ppc_direct.sv
module ppc_direct #(
   parameter int DC_W = 8
) (
   input  ppc_pkg::fmt_e    fmt,
   input  logic [15:0]      pix,
   output logic [DC_W-1:0]  r,
   output logic [DC_W-1:0]  g,
   output logic [DC_W-1:0]  b
);
   import ppc_pkg::*;

   logic [4:0]      red5;
   logic [DC_W-1:0] grn_from5;
   logic [DC_W-1:0] grn_from6;

   assign red5 = (fmt == FMT_RGB565) ? pix[15:11] : pix[14:10];

   ppc_widen #(.IN_W(5), .OUT_W(DC_W)) u_wr  (.din(red5),       .dout(r));
   ppc_widen #(.IN_W(5), .OUT_W(DC_W)) u_wg5 (.din(pix[9:5]),   .dout(grn_from5));
   ppc_widen #(.IN_W(6), .OUT_W(DC_W)) u_wg6 (.din(pix[10:5]),  .dout(grn_from6));
   ppc_widen #(.IN_W(5), .OUT_W(DC_W)) u_wb  (.din(pix[4:0]),   .dout(b));

   assign g = (fmt == FMT_RGB565) ? grn_from6 : grn_from5;
endmodule

// File: rtl/pal_pixel_conv.sv
module pal_pixel_conv #(
   parameter int IDX_W = 8,
   parameter int PAL_W = 6,
   parameter int DC_W  = 8,
   localparam int PIX_W  = 3 * DC_W,
   localparam int ADDR_W = (IDX_W > DC_W) ? IDX_W : DC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        fmt_sel,
   input  logic              fmt_bgr,
   input  logic              pix_valid,
   input  logic [PIX_W-1:0]  pix_data,
   input  logic              wr_en,
   input  logic              wr_lut,
   input  logic [1:0]        wr_chan,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DC_W-1:0]   wr_data,
   output logic              out_valid,
   output logic [DC_W-1:0]   out_r,
   output logic [DC_W-1:0]   out_g,
   output logic [DC_W-1:0]   out_b
);
   import ppc_pkg::*;

   generate
      if (PAL_W > DC_W || DC_W < 6 || DC_W > 10 || IDX_W > PIX_W) begin : g_param_chk
         $error("pal_pixel_conv: unsupported parameter combination");
      end
   endgenerate

   // format register, loaded only in idle cycles
   fmt_e act_fmt;
   logic act_bgr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_fmt <= FMT_INDEX;
         act_bgr <= 1'b0;
      end else if (!pix_valid) begin
         act_fmt <= fmt_e'(fmt_sel);
         act_bgr <= fmt_bgr;
      end
   end

   // stage 1: table reads and direct decode
   logic [DC_W-1:0] pal_wide [NUM_CH];
   logic [DC_W-1:0] gam_q    [NUM_CH];
   logic [DC_W-1:0] dir_r, dir_g, dir_b;
   logic            s1_valid;
   fmt_e            s1_fmt;
   logic [DC_W-1:0] s1_dr, s1_dg, s1_db;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic [PAL_W-1:0] pal_q;
         logic [DC_W-1:0]  gam_addr;
         logic             pal_we;
         logic             gam_we;

         assign pal_we   = wr_en && !wr_lut && (wr_chan == 2'(c));
         assign gam_we   = wr_en &&  wr_lut && (wr_chan == 2'(c));
         assign gam_addr = act_bgr ? pix_data[c*DC_W +: DC_W]
                                   : pix_data[(2-c)*DC_W +: DC_W];

         ppc_ram #(.AW(IDX_W), .DW(PAL_W)) u_pal (
            .clk   (clk),
            .we    (pal_we),
            .waddr (wr_addr[IDX_W-1:0]),
            .wdata (wr_data[PAL_W-1:0]),
            .raddr (pix_data[IDX_W-1:0]),
            .rdata (pal_q)
         );

         ppc_ram #(.AW(DC_W), .DW(DC_W)) u_gam (
            .clk   (clk),
            .we    (gam_we),
            .waddr (wr_addr[DC_W-1:0]),
            .wdata (wr_data),
            .raddr (gam_addr),
            .rdata (gam_q[c])
         );

         ppc_widen #(.IN_W(PAL_W), .OUT_W(DC_W)) u_wpal (
            .din  (pal_q),
            .dout (pal_wide[c])
         );
      end
   endgenerate

   ppc_direct #(.DC_W(DC_W)) u_direct (
      .fmt (act_fmt),
      .pix (pix_data[15:0]),
      .r   (dir_r),
      .g   (dir_g),
      .b   (dir_b)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_fmt   <= FMT_INDEX;
         s1_dr    <= '0;
         s1_dg    <= '0;
         s1_db    <= '0;
      end else begin
         s1_valid <= pix_valid;
         s1_fmt   <= act_fmt;
         s1_dr    <= dir_r;
         s1_dg    <= dir_g;
         s1_db    <= dir_b;
      end
   end

   // stage 2: format select into output registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_r     <= '0;
         out_g     <= '0;
         out_b     <= '0;
      end else begin
         out_valid <= s1_valid;
         if (!s1_valid) begin
            out_r <= '0;
            out_g <= '0;
            out_b <= '0;
         end else begin
            unique case (s1_fmt)
               FMT_INDEX: begin
                  out_r <= pal_wide[0];
                  out_g <= pal_wide[1];
                  out_b <= pal_wide[2];
               end
               FMT_TRUE: begin
                  out_r <= gam_q[0];
                  out_g <= gam_q[1];
                  out_b <= gam_q[2];
               end
               default: begin
                  out_r <= s1_dr;
                  out_g <= s1_dg;
                  out_b <= s1_db;
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/ppc_checker.sv
module ppc_checker #(
   parameter int PAL_W = 6,
   parameter int DC_W  = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            pix_valid,
   input logic [1:0]      act_fmt,
   input logic            act_bgr,
   input logic            s1_valid,
   input logic [1:0]      s1_fmt,
   input logic            out_valid,
   input logic [DC_W-1:0] out_r,
   input logic [DC_W-1:0] out_g,
   input logic [DC_W-1:0] out_b
);
   localparam int P6 = DC_W - PAL_W;
   localparam int P5 = DC_W - 5;

   AST_LAT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> ##1 out_valid);                                        // R2
   AST_LAT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> ##1 !out_valid);                                      // R2
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_r == '0 && out_g == '0 && out_b == '0));         // R1
   AST_FMT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> ($stable(act_fmt) && $stable(act_bgr)));               // R10
   AST_IDX_WIDEN: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && s1_fmt == 2'b00) |=>
         (out_r[P6-1:0] == out_r[DC_W-1 -: P6] &&
          out_g[P6-1:0] == out_g[DC_W-1 -: P6] &&
          out_b[P6-1:0] == out_b[DC_W-1 -: P6]));                          // R3
   AST_555_WIDEN: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && s1_fmt == 2'b01) |=>
         (out_r[P5-1:0] == out_r[DC_W-1 -: P5] &&
          out_g[P5-1:0] == out_g[DC_W-1 -: P5] &&
          out_b[P5-1:0] == out_b[DC_W-1 -: P5]));                          // R4
endmodule

bind pal_pixel_conv ppc_checker #(.PAL_W(PAL_W), .DC_W(DC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pix_valid (pix_valid),
   .act_fmt   (act_fmt),
   .act_bgr   (act_bgr),
   .s1_valid  (s1_valid),
   .s1_fmt    (s1_fmt),
   .out_valid (out_valid),
   .out_r     (out_r),
   .out_g     (out_g),
   .out_b     (out_b)
);

// File: tb/pal_pixel_conv_tb.sv
module pal_pixel_conv_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  fmt_sel = 2'b00;
   logic        fmt_bgr = 1'b0;
   logic        pix_valid = 1'b0;
   logic [23:0] pix_data = '0;
   logic        wr_en = 1'b0;
   logic        wr_lut = 1'b0;
   logic [1:0]  wr_chan = 2'b00;
   logic [7:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        out_valid;
   logic [7:0]  out_r, out_g, out_b;

   always #2 clk = ~clk;   // 250 MHz

   pal_pixel_conv u_dut (
      .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .fmt_bgr(fmt_bgr),
      .pix_valid(pix_valid), .pix_data(pix_data), .wr_en(wr_en),
      .wr_lut(wr_lut), .wr_chan(wr_chan), .wr_addr(wr_addr),
      .wr_data(wr_data), .out_valid(out_valid), .out_r(out_r),
      .out_g(out_g), .out_b(out_b)
   );

   typedef struct {
      logic [7:0] r, g, b;
      int         due;
      string      tag;
   } exp_t;

   exp_t       sb[$];
   int         checks = 0;
   int         errors = 0;
   int         cyc = 0;
   bit         done = 0;
   logic [5:0] m_pal [3][256];
   logic [7:0] m_gam [3][256];
   logic [1:0] m_fmt = 2'b00;
   logic       m_bgr = 1'b0;
   string      cur_tag = "R3";

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [7:0] w5(input logic [4:0] x);
      return {x, x[4:2]};
   endfunction
   function automatic logic [7:0] w6(input logic [5:0] x);
      return {x, x[5:4]};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   // driver: one cycle of stimulus, expectations pushed before the model's tables update
   task automatic step(input bit we, input bit lut, input int ch, input int addr,
                       input int data, input bit pv, input logic [23:0] pd);
      exp_t e;
      logic [7:0] b2, b1, b0;
      @(negedge clk);
      wr_en = we; wr_lut = lut; wr_chan = 2'(ch); wr_addr = 8'(addr);
      wr_data = 8'(data); pix_valid = pv; pix_data = pd;
      if (pv) begin
         b2 = pd[23:16]; b1 = pd[15:8]; b0 = pd[7:0];
         case (m_fmt)
            2'b00: begin
               e.r = w6(m_pal[0][b0]); e.g = w6(m_pal[1][b0]); e.b = w6(m_pal[2][b0]);
            end
            2'b01: begin
               e.r = w5(pd[14:10]); e.g = w5(pd[9:5]); e.b = w5(pd[4:0]);
            end
            2'b10: begin
               e.r = w5(pd[15:11]); e.g = w6(pd[10:5]); e.b = w5(pd[4:0]);
            end
            default: begin
               e.g = m_gam[1][b1];
               e.r = m_bgr ? m_gam[0][b0] : m_gam[0][b2];
               e.b = m_bgr ? m_gam[2][b2] : m_gam[2][b0];
            end
         endcase
         e.due = cyc + 2;
         e.tag = cur_tag;
         sb.push_back(e);
      end else begin
         m_fmt = fmt_sel;
         m_bgr = fmt_bgr;
      end
      if (we && ch < 3) begin
         if (lut) m_gam[ch][addr] = 8'(data);
         else     m_pal[ch][addr] = 6'(data);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 24'h0);
   endtask

   task automatic burst(input int n, input logic [23:0] mask_or);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 1, 24'($urandom) | mask_or);
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && out_valid && !done) begin
         if (sb.size() == 0) begin
            check("R2 unexpected out_valid", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " colour"}, {8'h0, out_r, out_g, out_b}, {8'h0, e.r, e.g, e.b});
            check("R2 latency", 32'(cyc), 32'(e.due));
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset outputs", {7'h0, out_valid, out_r, out_g, out_b}, 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 after reset", {7'h0, out_valid, out_r, out_g, out_b}, 32'h0);

      cur_tag = "R8";
      for (int a = 0; a < 256; a++)
         for (int c = 0; c < 3; c++) begin
            step(1, 0, c, a, (a * 3 + c * 29 + 64) & 8'hff, 0, 24'h0);
            step(1, 1, c, a, (a ^ (c * 8'h55)) + c, 0, 24'h0);
         end
      idle(1);

      // indexed, upper bits random
      cur_tag = "R3";
      burst(40, 24'h0);
      burst(10, 24'hffff00);
      idle(1);

      // palette collision then re-read
      cur_tag = "R9";
      step(1, 0, 0, 8'h5a, 8'h3c, 1, 24'h00005a);
      cur_tag = "R8";
      step(0, 0, 0, 0, 0, 1, 24'h00005a);
      idle(1);

      cur_tag = "R4";
      fmt_sel = 2'b01; idle(1);
      burst(30, 24'h0);
      burst(10, 24'h008000);
      idle(1);

      cur_tag = "R5";
      fmt_sel = 2'b10; idle(1);
      burst(30, 24'h0);

      // format request mid-burst must wait for an idle cycle
      cur_tag = "R10";
      fmt_sel = 2'b01;
      burst(8, 24'h0);
      idle(1);
      burst(8, 24'h0);
      idle(1);

      cur_tag = "R6";
      fmt_sel = 2'b11; fmt_bgr = 1'b0; idle(1);
      burst(40, 24'h0);
      cur_tag = "R9";
      step(1, 1, 0, 8'h77, 8'he1, 1, 24'h770000);
      cur_tag = "R8";
      step(0, 0, 0, 0, 0, 1, 24'h770000);
      idle(1);

      cur_tag = "R7";
      fmt_bgr = 1'b1; idle(1);
      burst(40, 24'h0);
      step(0, 0, 0, 0, 0, 1, 24'h10aa77);
      idle(4);

      check("R2 scoreboard drained", 32'(sb.size()), 32'd0);
      check("R1 idle outputs", {7'h0, out_valid, out_r, out_g, out_b}, 32'h0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule